// File: doc/BRIEF.md
# Trailing Port-Tag Inserter and Extractor

This block sits between a host MAC and the host-facing port of a small three-port switch. The switch marks each frame with one extra byte after the final payload byte. The block adds that byte to frames the host sends and removes it from frames the host receives. Each direction is a byte-wide stream with valid, ready and last.

On the send path, the caller gives a destination port index with each frame. When tagging is on, the block forwards the payload unchanged and then emits one tag byte. The tag byte has only the bit for the destination port set. The stream's last marker moves from the payload's final byte onto the tag byte.

On the receive path, the block holds each byte back by one beat so that it knows which byte is the final one. The final byte is consumed and not forwarded. Its low three bits are reported as the source port, beside the forwarded byte that now carries last. A frame of a single byte has no payload, so it is dropped and flagged.

A control byte switches tagging on and off. When tagging is off, both paths pass frames through unchanged.

Top module: `tailtag_top`

## Requirements
- R1: Tagging is enabled exactly when bit 6 of the control byte `ctrl_i` is 1. All other control bits have no effect on either path.
- R2: With tagging on, every send-path payload byte leaves unchanged, with last deasserted. The very next output beat after the byte that carried input last is the tag byte, with last asserted.
- R3: The tag byte for destination index n (0, 1 or 2), sampled on the input beat that carries last, is `1 << n`. For an index of 3 or more the tag byte is 0x00.
- R4: While a tag byte waits to be sent, the send path does not accept input (`tx_s_ready_o` is 0).
- R5: With tagging on, the receive path forwards every byte of a frame except the final one, in order and unchanged. Last is asserted on the byte that came before the final one.
- R6: The reported source port equals bits [2:0] of the removed final byte. It is shown on the forwarded beat that carries last, and it is 0 on all other output beats.
- R7: With tagging on, a received frame of exactly one byte produces no output beat. `rx_drop_o` is 1 for exactly the one cycle that follows acceptance of that byte.
- R8: With tagging off, both paths pass data and last through unchanged, add and remove nothing, and report source port 0. `rx_drop_o` stays 0.
- R9: During reset and in the first cycle after it, neither output stream is valid and `rx_drop_o` is 0.
- R10: An output beat that is valid but not accepted stays valid with the same data in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 8 | Control byte; bit 6 enables tagging |
| tx_s_data_i | input | 8 | Send path: payload byte from the host |
| tx_s_valid_i | input | 1 | Send path: input beat valid |
| tx_s_last_i | input | 1 | Send path: final payload byte of the frame |
| tx_s_dport_i | input | 3 | Send path: destination port index, sampled with last |
| tx_s_ready_o | output | 1 | Send path: input beat accepted |
| tx_m_data_o | output | 8 | Send path: byte to the switch |
| tx_m_valid_o | output | 1 | Send path: output beat valid |
| tx_m_last_o | output | 1 | Send path: final byte, which is the tag when tagging is on |
| tx_m_ready_i | input | 1 | Send path: switch side ready |
| rx_s_data_i | input | 8 | Receive path: byte from the switch |
| rx_s_valid_i | input | 1 | Receive path: input beat valid |
| rx_s_last_i | input | 1 | Receive path: final byte of the frame |
| rx_s_ready_o | output | 1 | Receive path: input beat accepted |
| rx_m_data_o | output | 8 | Receive path: payload byte to the host |
| rx_m_valid_o | output | 1 | Receive path: output beat valid |
| rx_m_last_o | output | 1 | Receive path: final payload byte |
| rx_m_sport_o | output | 3 | Receive path: source port, shown with last |
| rx_m_ready_i | input | 1 | Receive path: host side ready |
| rx_drop_o | output | 1 | One-cycle pulse for a dropped one-byte frame |

## Verification
The assertions take for granted that the control byte changes only while both paths are idle between frames. They also assume that a valid input beat holds its data, last and port index until accepted. Without these, the stall-stability property and the tag-follows-last property would not hold.

The stimulus keeps within both assumptions. It writes the control byte only once every queue has drained. It raises valid only with a complete beat and never withdraws a beat before it is accepted. Ready on both outputs is throttled at random. Frames of one, two and longer lengths exercise the drop case, the single-payload case and back-to-back tagging.

// File: rtl/tailtag_pkg.sv
package tailtag_pkg;
  localparam int unsigned CTRL_W       = 8;
  localparam int unsigned CTRL_TAG_BIT = 6;

  typedef enum logic {
    TX_PAYLOAD = 1'b0,
    TX_TAG     = 1'b1
  } tx_state_e;
endpackage

// File: rtl/tailtag_mode.sv
module tailtag_mode
  import tailtag_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              tag_en_o
);
  logic unused_ctrl;

  assign tag_en_o    = ctrl_i[CTRL_TAG_BIT];
  assign unused_ctrl = ^ctrl_i;
endmodule

// File: rtl/tailtag_ins.sv
module tailtag_ins
  import tailtag_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned IDX_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tag_en_i,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_valid_i,
  input  logic              s_last_i,
  input  logic [IDX_W-1:0]  s_dport_i,
  output logic              s_ready_o,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_valid_o,
  output logic              m_last_o,
  input  logic              m_ready_i
);
  tx_state_e         state_q;
  logic [IDX_W-1:0]  dport_q;
  logic [DATA_W-1:0] tag_byte;

  // one-hot mask; indices outside the port range give an empty tag
  for (genvar b = 0; b < DATA_W; b++) begin : g_tag
    if (b < NUM_PORTS) begin : g_live
      assign tag_byte[b] = (dport_q == IDX_W'(b));
    end else begin : g_dead
      assign tag_byte[b] = 1'b0;
    end
  end

  always_comb begin
    if (state_q == TX_TAG) begin
      m_valid_o = 1'b1;
      m_data_o  = tag_byte;
      m_last_o  = 1'b1;
      s_ready_o = 1'b0;
    end else begin
      m_valid_o = s_valid_i;
      m_data_o  = s_data_i;
      m_last_o  = s_last_i & ~tag_en_i;
      s_ready_o = m_ready_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_PAYLOAD;
      dport_q <= '0;
    end else if (state_q == TX_PAYLOAD) begin
      if (tag_en_i && s_valid_i && m_ready_i && s_last_i) begin
        state_q <= TX_TAG;
        dport_q <= s_dport_i;
      end
    end else if (m_ready_i) begin
      state_q <= TX_PAYLOAD;
    end
  end
endmodule

// File: rtl/tailtag_ext.sv
module tailtag_ext #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tag_en_i,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_valid_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_valid_o,
  output logic              m_last_o,
  output logic [IDX_W-1:0]  m_sport_o,
  input  logic              m_ready_i,
  output logic              drop_o
);
  logic              hold_vld_q;
  logic [DATA_W-1:0] hold_q;
  logic              drop_q;
  logic              s_fire;

  always_comb begin
    if (tag_en_i) begin
      // held byte leaves only once its successor is visible
      m_valid_o = hold_vld_q & s_valid_i;
      m_data_o  = hold_q;
      m_last_o  = s_last_i;
      s_ready_o = ~hold_vld_q | m_ready_i;
      m_sport_o = (hold_vld_q & s_valid_i & s_last_i) ? s_data_i[IDX_W-1:0] : '0;
    end else begin
      m_valid_o = s_valid_i;
      m_data_o  = s_data_i;
      m_last_o  = s_last_i;
      s_ready_o = m_ready_i;
      m_sport_o = '0;
    end
  end

  assign s_fire = s_valid_i & s_ready_o;
  assign drop_o = drop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld_q <= 1'b0;
      hold_q     <= '0;
      drop_q     <= 1'b0;
    end else begin
      drop_q <= tag_en_i & s_fire & s_last_i & ~hold_vld_q;
      if (tag_en_i && s_fire) begin
        hold_vld_q <= ~s_last_i;
        if (!s_last_i) hold_q <= s_data_i;
      end
    end
  end
endmodule

// File: rtl/tailtag_top.sv
module tailtag_top
  import tailtag_pkg::*;
#(
  parameter  int unsigned DATA_W    = 8,
  parameter  int unsigned NUM_PORTS = 3,
  localparam int unsigned IDX_W     = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [DATA_W-1:0] tx_s_data_i,
  input  logic              tx_s_valid_i,
  input  logic              tx_s_last_i,
  input  logic [IDX_W-1:0]  tx_s_dport_i,
  output logic              tx_s_ready_o,
  output logic [DATA_W-1:0] tx_m_data_o,
  output logic              tx_m_valid_o,
  output logic              tx_m_last_o,
  input  logic              tx_m_ready_i,
  input  logic [DATA_W-1:0] rx_s_data_i,
  input  logic              rx_s_valid_i,
  input  logic              rx_s_last_i,
  output logic              rx_s_ready_o,
  output logic [DATA_W-1:0] rx_m_data_o,
  output logic              rx_m_valid_o,
  output logic              rx_m_last_o,
  output logic [IDX_W-1:0]  rx_m_sport_o,
  input  logic              rx_m_ready_i,
  output logic              rx_drop_o
);
  logic tag_en;

  tailtag_mode u_mode (
    .ctrl_i   (ctrl_i),
    .tag_en_o (tag_en)
  );

  tailtag_ins #(
    .DATA_W    (DATA_W),
    .NUM_PORTS (NUM_PORTS),
    .IDX_W     (IDX_W)
  ) u_ins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tag_en_i  (tag_en),
    .s_data_i  (tx_s_data_i),
    .s_valid_i (tx_s_valid_i),
    .s_last_i  (tx_s_last_i),
    .s_dport_i (tx_s_dport_i),
    .s_ready_o (tx_s_ready_o),
    .m_data_o  (tx_m_data_o),
    .m_valid_o (tx_m_valid_o),
    .m_last_o  (tx_m_last_o),
    .m_ready_i (tx_m_ready_i)
  );

  tailtag_ext #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_ext (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tag_en_i  (tag_en),
    .s_data_i  (rx_s_data_i),
    .s_valid_i (rx_s_valid_i),
    .s_last_i  (rx_s_last_i),
    .s_ready_o (rx_s_ready_o),
    .m_data_o  (rx_m_data_o),
    .m_valid_o (rx_m_valid_o),
    .m_last_o  (rx_m_last_o),
    .m_sport_o (rx_m_sport_o),
    .m_ready_i (rx_m_ready_i),
    .drop_o    (rx_drop_o)
  );
endmodule

// File: rtl/tailtag_chk.sv
module tailtag_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tag_en_i,
  input logic [DATA_W-1:0] tx_m_data_i,
  input logic              tx_m_valid_i,
  input logic              tx_m_last_i,
  input logic              tx_m_ready_i,
  input logic              tx_s_valid_i,
  input logic              tx_s_ready_i,
  input logic              tx_s_last_i,
  input logic [DATA_W-1:0] rx_m_data_i,
  input logic              rx_m_valid_i,
  input logic              rx_m_ready_i,
  input logic [IDX_W-1:0]  rx_m_sport_i,
  input logic              rx_s_valid_i,
  input logic              rx_s_ready_i,
  input logic              rx_s_last_i,
  input logic              rx_drop_i
);
  AST_TAG_FOLLOWS_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_en_i && tx_s_valid_i && tx_s_ready_i && tx_s_last_i) |=> (tx_m_valid_i && tx_m_last_i)); // R2
  AST_TAG_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_en_i && tx_m_valid_i && tx_m_last_i) |-> $onehot0(tx_m_data_i)); // R3
  AST_TAG_BLOCKS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_en_i && tx_s_valid_i && tx_s_ready_i && tx_s_last_i) |=> !tx_s_ready_i); // R4
  AST_RX_OUT_NEEDS_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_en_i && rx_m_valid_i) |-> rx_s_valid_i); // R5
  AST_DROP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_drop_i |-> $past(tag_en_i && rx_s_valid_i && rx_s_ready_i && rx_s_last_i && !rx_m_valid_i)); // R7
  AST_PORT_ZERO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tag_en_i |-> (rx_m_sport_i == '0)); // R8
  AST_TX_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_m_valid_i && !tx_m_ready_i) |=> (tx_m_valid_i && $stable(tx_m_data_i))); // R10
  AST_RX_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_m_valid_i && !rx_m_ready_i) |=> (rx_m_valid_i && $stable(rx_m_data_i))); // R10
endmodule

bind tailtag_top tailtag_chk #(
  .DATA_W (DATA_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tag_en_i     (ctrl_i[tailtag_pkg::CTRL_TAG_BIT]),
  .tx_m_data_i  (tx_m_data_o),
  .tx_m_valid_i (tx_m_valid_o),
  .tx_m_last_i  (tx_m_last_o),
  .tx_m_ready_i (tx_m_ready_i),
  .tx_s_valid_i (tx_s_valid_i),
  .tx_s_ready_i (tx_s_ready_o),
  .tx_s_last_i  (tx_s_last_i),
  .rx_m_data_i  (rx_m_data_o),
  .rx_m_valid_i (rx_m_valid_o),
  .rx_m_ready_i (rx_m_ready_i),
  .rx_m_sport_i (rx_m_sport_o),
  .rx_s_valid_i (rx_s_valid_i),
  .rx_s_ready_i (rx_s_ready_o),
  .rx_s_last_i  (rx_s_last_i),
  .rx_drop_i    (rx_drop_o)
);

// File: tb/tailtag_top_tb.sv
`timescale 1ns/1ps
module tailtag_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic [7:0] tx_s_data = '0, tx_m_data, rx_s_data = '0, rx_m_data;
  logic       tx_s_valid = 0, tx_s_last = 0, tx_s_ready, tx_m_valid, tx_m_last, tx_m_ready = 0;
  logic [2:0] tx_s_dport = '0, rx_m_sport;
  logic       rx_s_valid = 0, rx_s_last = 0, rx_s_ready, rx_m_valid, rx_m_last, rx_m_ready = 0;
  logic       rx_drop;

  always #2 clk = ~clk;

  tailtag_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl),
    .tx_s_data_i(tx_s_data), .tx_s_valid_i(tx_s_valid), .tx_s_last_i(tx_s_last),
    .tx_s_dport_i(tx_s_dport), .tx_s_ready_o(tx_s_ready),
    .tx_m_data_o(tx_m_data), .tx_m_valid_o(tx_m_valid), .tx_m_last_o(tx_m_last),
    .tx_m_ready_i(tx_m_ready),
    .rx_s_data_i(rx_s_data), .rx_s_valid_i(rx_s_valid), .rx_s_last_i(rx_s_last),
    .rx_s_ready_o(rx_s_ready),
    .rx_m_data_o(rx_m_data), .rx_m_valid_o(rx_m_valid), .rx_m_last_o(rx_m_last),
    .rx_m_sport_o(rx_m_sport), .rx_m_ready_i(rx_m_ready), .rx_drop_o(rx_drop)
  );

  typedef struct { logic [7:0] d; logic l; logic [2:0] p; logic tag; } beat_t;
  beat_t tx_in[$], tx_exp[$], rx_in[$], rx_exp[$];
  int n_cmp = 0, n_bad = 0;
  bit en_model = 0;
  bit pend_drop = 0, rx_first = 1, tx_acc = 0, rx_acc = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic add_tx(int len, int dport);
    for (int i = 0; i < len; i++) begin
      beat_t b;
      b.d = 8'($urandom); b.l = (i == len - 1); b.p = 3'(dport); b.tag = 0;
      tx_in.push_back(b);
      b.l = b.l & !en_model;
      tx_exp.push_back(b);
    end
    if (en_model) begin
      beat_t t;
      t.d = (dport < 3) ? 8'(1 << dport) : 8'h00; t.l = 1; t.p = 0; t.tag = 1;
      tx_exp.push_back(t);
    end
  endtask

  task automatic add_rx(int len, int sport);
    for (int i = 0; i < len; i++) begin
      beat_t b;
      b.d = 8'($urandom); b.l = (i == len - 1); b.p = 0; b.tag = 0;
      if (b.l) b.d[2:0] = 3'(sport);
      rx_in.push_back(b);
      if (!en_model) rx_exp.push_back(b);
      else if (i < len - 1) begin
        b.l = (i == len - 2); b.p = b.l ? 3'(sport) : 3'd0;
        rx_exp.push_back(b);
      end
    end
  endtask

  task automatic run_until_idle();
    int guard = 0;
    while (tx_in.size() || rx_in.size() || tx_exp.size() || rx_exp.size() || pend_drop) begin
      @(posedge clk); #1;
      if (tx_acc) begin void'(tx_in.pop_front()); tx_s_valid = 0; tx_acc = 0; end
      if (rx_acc) begin void'(rx_in.pop_front()); rx_s_valid = 0; rx_acc = 0; end
      if (!tx_s_valid && tx_in.size() && ($urandom % 3) != 0) begin
        tx_s_valid = 1; tx_s_data = tx_in[0].d; tx_s_last = tx_in[0].l; tx_s_dport = tx_in[0].p;
      end
      if (!rx_s_valid && rx_in.size() && ($urandom % 3) != 0) begin
        rx_s_valid = 1; rx_s_data = rx_in[0].d; rx_s_last = rx_in[0].l;
      end
      tx_m_ready = ($urandom % 4) != 0;
      rx_m_ready = ($urandom % 4) != 0;
      @(negedge clk);
      chk(rx_drop == pend_drop, "R7", "drop pulse", rx_drop, pend_drop);
      pend_drop = 0;
      if (!en_model) chk(rx_m_sport == 0, "R8", "sport while off", rx_m_sport, 0);
      if (tx_exp.size() && tx_exp[0].tag) begin
        chk(tx_m_valid == 1, "R2", "tag beat valid", tx_m_valid, 1);
        chk(tx_s_ready == 0, "R4", "input ready during tag", tx_s_ready, 0);
      end
      if (tx_s_valid && tx_s_ready) tx_acc = 1;
      if (rx_s_valid && rx_s_ready) begin
        rx_acc = 1;
        if (en_model && rx_first && rx_s_last) pend_drop = 1;
        rx_first = rx_s_last;
      end
      if (tx_m_valid && tx_m_ready) begin
        if (tx_exp.size() == 0) chk(0, "R2", "unexpected tx beat", tx_m_data, 0);
        else begin
          beat_t e = tx_exp.pop_front();
          chk(tx_m_data == e.d, e.tag ? "R3" : "R2", "tx data", tx_m_data, e.d);
          chk(tx_m_last == e.l, e.tag ? "R2" : (en_model ? "R2" : "R8"), "tx last", tx_m_last, e.l);
        end
      end
      if (rx_m_valid && rx_m_ready) begin
        if (rx_exp.size() == 0) chk(0, en_model ? "R7" : "R8", "unexpected rx beat", rx_m_data, 0);
        else begin
          beat_t e = rx_exp.pop_front();
          chk(rx_m_data == e.d, en_model ? "R5" : "R8", "rx data", rx_m_data, e.d);
          chk(rx_m_last == e.l, en_model ? "R5" : "R8", "rx last", rx_m_last, e.l);
          chk(rx_m_sport == e.p, en_model ? "R6" : "R8", "rx sport", rx_m_sport, e.p);
        end
      end
      guard++;
      if (guard > 20000) begin
        chk(0, "R10", "watchdog expired", guard, 0);
        tx_in.delete(); rx_in.delete(); tx_exp.delete(); rx_exp.delete(); pend_drop = 0;
      end
    end
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_m_valid == 0, "R9", "tx valid in reset", tx_m_valid, 0);
    chk(rx_m_valid == 0, "R9", "rx valid in reset", rx_m_valid, 0);
    chk(rx_drop == 0, "R9", "drop in reset", rx_drop, 0);
    rst_n = 1;
    @(negedge clk);
    chk(tx_m_valid == 0 && rx_m_valid == 0 && rx_drop == 0, "R9", "idle after reset",
        {tx_m_valid, rx_m_valid, rx_drop}, 0);

    // R1: unrelated control bits set alongside enable
    @(posedge clk); #1; ctrl = 8'hC5; en_model = 1;
    add_tx(1, 0); add_tx(2, 1); add_tx(5, 2); add_tx(3, 3); add_tx(2, 7); add_tx(4, 1);
    add_rx(2, 1); add_rx(1, 5); add_rx(4, 2); add_rx(1, 0); add_rx(1, 7);
    add_rx(6, 0); add_rx(3, 6); add_rx(2, 3);
    run_until_idle();

    // R1, R8: every bit except enable set
    @(posedge clk); #1; ctrl = 8'hBF; en_model = 0; rx_first = 1;
    add_tx(3, 2); add_tx(1, 0); add_tx(4, 1);
    add_rx(3, 4); add_rx(1, 2); add_rx(5, 1);
    run_until_idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule